// File: doc/BRIEF.md
# Accumulator CPU Core with Prefix-Coded Opcodes

A compact 16-bit multi-cycle processor for the classic mailbox teaching machine. Register r0 serves as the accumulator, and every instruction is a single 16-bit word. The opcode is a prefix code whose length depends on the instruction: 4 bits for the memory arithmetic and transfer group, 5 bits for halt, 7 bits for branches, and 9 bits for port input and output. Arithmetic is plain 16-bit two's complement, so results pass well beyond three decimal digits. For example, 999 + 999 gives 1998.

The core drives a single word-addressed synchronous memory that holds both program and data. The memory returns read data one cycle after it samples an address. The address of every memory operand and of every branch target is the low 8 bits of the instruction. This means the encoding of a load or store with a zero address field plus an address number gives a working instruction, and a program may store such a word and later execute it. Input uses a valid/ready handshake. Output gives a one-cycle strobe with a numeric-or-character flag. A counter reports how many instructions have completed.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high and on the first cycle after reset, the outputs are as follows: halted, illegal, out_valid, in_ready and mem_we are 0, instr_count is 0, and mem_addr is 0, so the first instruction is fetched from address 0.
- R2: ADD (bits[15:12]=1100) and SUB (1101) combine the accumulator with mem[bits[7:0]] in 16-bit two's complement, wrapping only at 16 bits.
- R3: LDA (1111) loads the accumulator from mem[bits[7:0]]. STA (1110) writes the accumulator to mem[bits[7:0]] and writes nowhere else.
- R4: The branches are selected by bits[15:9]. BRA (1000000) always branches. BRZ (1001010) branches when the accumulator is zero. BRP (1001000) branches when accumulator bit 15 is clear. The target is bits[7:0]. A branch that is not taken continues at the next address.
- R5: INP (bits[15:7]=011100010) raises in_ready and waits. The accumulator takes in_data in the cycle where in_valid and in_ready are both high. In_ready stays high for every waiting cycle and does not rise otherwise.
- R6: OUT (bits[15:7]=011100011) drives the accumulator onto out_data with out_valid high for exactly one cycle. out_is_char is 1 when bits[6:0] equal 2 and 0 for any other device code.
- R7: Any word whose bits[15:11] are 00000 halts the core. halted then stays high, no further memory write occurs, and instr_count no longer changes.
- R8: A word that matches none of the prefixes sets both illegal and halted, and it is not counted.
- R9: instr_count rises by exactly 1 for each completed instruction, including the final halt.
- R10: A word written by STA and then fetched executes as the instruction it encodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory word address (registered) |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data (the accumulator) |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| in_data | input | 16 | Input port value |
| in_valid | input | 1 | Input value is available |
| in_ready | output | 1 | Core is waiting in INP |
| out_data | output | 16 | Output port value |
| out_valid | output | 1 | One-cycle output strobe |
| out_is_char | output | 1 | Output is a character (device 2) |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stop was caused by an unknown opcode |
| instr_count | output | 32 | Completed instruction count |

## Verification
The hardest situation to reach from the ports is an instruction that the program itself writes and then fetches a few cycles later. That case depends on the store landing before the fetch of the same address. The bench builds it from a data word holding a load with a zero address, adds an address to it, stores the result just ahead of the program counter, and checks both the rewritten memory word and the value the new instruction produces. The input stall is reached by holding in_valid low for a chosen number of waiting cycles. The bench then compares the count of in_ready cycles with that choice.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int WORD_W   = 16;
  localparam int DEV_W    = 7;
  localparam int CHAR_DEV = 2;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WAIT, ST_HALT
  } state_t;

  typedef enum logic [3:0] {
    OP_HLT, OP_ADD, OP_SUB, OP_STA, OP_LDA,
    OP_BRA, OP_BRZ, OP_BRP, OP_INP, OP_OUT, OP_BAD
  } op_t;

  typedef enum logic [1:0] {
    FN_ADD, FN_SUB, FN_PASS
  } fn_t;
endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [WORD_W-1:0] ir,
  output op_t               op,
  output logic [ADDR_W-1:0] operand,
  output logic              is_char
);
  // Prefix classes examined on the top nine bits; longer codes never
  // collide with shorter ones, so the order of the items is free.
  always_comb begin
    casez (ir[15:7])
      9'b11???????: begin
        case (ir[13:12])
          2'b00:   op = OP_ADD;
          2'b01:   op = OP_SUB;
          2'b10:   op = OP_STA;
          default: op = OP_LDA;
        endcase
      end
      9'b00000????: op = OP_HLT;
      9'b1000000??: op = OP_BRA;
      9'b1001010??: op = OP_BRZ;
      9'b1001000??: op = OP_BRP;
      9'b011100010: op = OP_INP;
      9'b011100011: op = OP_OUT;
      default:      op = OP_BAD;
    endcase
  end

  assign operand = ir[ADDR_W-1:0];
  assign is_char = (ir[DEV_W-1:0] == DEV_W'(CHAR_DEV));
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 16
) (
  input  fn_t          fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/acc_cpu_cond.sv
module acc_cpu_cond
  import acc_cpu_pkg::*;
#(
  parameter int W = 16
) (
  input  op_t          op,
  input  logic [W-1:0] acc,
  output logic         take
);
  logic is_zero;
  logic is_neg;

  assign is_zero = (acc == '0);
  assign is_neg  = acc[W-1];

  always_comb begin
    case (op)
      OP_BRA:  take = 1'b1;
      OP_BRZ:  take = is_zero;
      OP_BRP:  take = !is_neg;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_is_char,
  output logic              halted,
  output logic              illegal,
  output logic [CNT_W-1:0]  instr_count
);
  localparam logic [ADDR_W-1:0] PC_STEP  = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_STEP = CNT_W'(1);

  state_t            state;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] ir;
  logic [WORD_W-1:0] acc;

  op_t               op;
  logic [ADDR_W-1:0] operand;
  logic              dev_char;
  fn_t               fn;
  logic [WORD_W-1:0] alu_y;
  logic              take;

  acc_cpu_decode #(.ADDR_W(ADDR_W)) u_dec (
    .ir      (ir),
    .op      (op),
    .operand (operand),
    .is_char (dev_char)
  );

  always_comb begin
    case (op)
      OP_ADD:  fn = FN_ADD;
      OP_SUB:  fn = FN_SUB;
      default: fn = FN_PASS;
    endcase
  end

  acc_cpu_alu #(.W(WORD_W)) u_alu (
    .fn (fn),
    .a  (acc),
    .b  (mem_rdata),
    .y  (alu_y)
  );

  acc_cpu_cond #(.W(WORD_W)) u_cond (
    .op   (op),
    .acc  (acc),
    .take (take)
  );

  assign mem_addr  = addr_q;
  assign mem_wdata = acc;
  assign mem_we    = (state == ST_EXEC) && (op == OP_STA);
  assign in_ready  = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    out_valid <= 1'b0;
    if (rst) begin
      state       <= ST_FETCH;
      pc          <= '0;
      addr_q      <= '0;
      ir          <= '0;
      acc         <= '0;
      instr_count <= '0;
      halted      <= 1'b0;
      illegal     <= 1'b0;
      out_data    <= '0;
      out_is_char <= 1'b0;
    end else begin
      case (state)
        ST_FETCH: state <= ST_DECODE;
        ST_DECODE: begin
          ir     <= mem_rdata;
          pc     <= pc + PC_STEP;
          addr_q <= mem_rdata[ADDR_W-1:0];
          state  <= ST_EXEC;
        end
        ST_EXEC: begin
          case (op)
            OP_ADD, OP_SUB, OP_LDA: state <= ST_MEM;
            OP_INP:                 state <= ST_WAIT;
            OP_STA: begin
              instr_count <= instr_count + CNT_STEP;
              addr_q      <= pc;
              state       <= ST_FETCH;
            end
            OP_BRA, OP_BRZ, OP_BRP: begin
              instr_count <= instr_count + CNT_STEP;
              if (take) begin
                pc     <= operand;
                addr_q <= operand;
              end else begin
                addr_q <= pc;
              end
              state <= ST_FETCH;
            end
            OP_OUT: begin
              out_valid   <= 1'b1;
              out_data    <= acc;
              out_is_char <= dev_char;
              instr_count <= instr_count + CNT_STEP;
              addr_q      <= pc;
              state       <= ST_FETCH;
            end
            OP_HLT: begin
              halted      <= 1'b1;
              instr_count <= instr_count + CNT_STEP;
              state       <= ST_HALT;
            end
            default: begin
              illegal <= 1'b1;
              halted  <= 1'b1;
              state   <= ST_HALT;
            end
          endcase
        end
        ST_MEM: begin
          acc         <= alu_y;
          instr_count <= instr_count + CNT_STEP;
          addr_q      <= pc;
          state       <= ST_FETCH;
        end
        ST_WAIT: begin
          if (in_valid) begin
            acc         <= in_data;
            instr_count <= instr_count + CNT_STEP;
            addr_q      <= pc;
            state       <= ST_FETCH;
          end
        end
        default: state <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_we,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             halted,
  input logic             illegal,
  input logic [CNT_W-1:0] instr_count
);
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) halted |=> halted); // R7
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst) halted |-> !mem_we); // R7
  AST_HALT_FROZEN_COUNT: assert property (@(posedge clk) disable iff (rst) halted |=> $stable(instr_count)); // R7
  AST_ILLEGAL_HALTS: assert property (@(posedge clk) disable iff (rst) illegal |-> halted); // R8
  AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid); // R6
  AST_READY_NOT_HALTED: assert property (@(posedge clk) disable iff (rst) in_ready |-> !halted); // R5
  AST_INPUT_RETIRES: assert property (@(posedge clk) disable iff (rst) (in_ready && in_valid) |=> (instr_count == $past(instr_count) + CNT_W'(1))); // R5
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst) (in_ready && !in_valid) |=> in_ready); // R5
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst) !$stable(instr_count) |-> (instr_count == $past(instr_count) + CNT_W'(1))); // R9
endmodule

bind acc_cpu acc_cpu_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mem_we      (mem_we),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .halted      (halted),
  .illegal     (illegal),
  .instr_count (instr_count)
);

// File: tb/acc_cpu_test.sv
`timescale 1ns/1ps
module acc_cpu_test;
  localparam int AW = 8;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata;
  logic [15:0]   in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [15:0]   out_data;
  logic          out_valid;
  logic          out_is_char;
  logic          halted;
  logic          illegal;
  logic [CW-1:0] instr_count;

  always #2 clk = ~clk;

  acc_cpu #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_is_char(out_is_char), .halted(halted),
    .illegal(illegal), .instr_count(instr_count)
  );

  logic [15:0] mem [256];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  int checks = 0;
  int failures = 0;
  logic [15:0] cap_val [8];
  logic        cap_chr [8];
  int          cap_n;
  int          ready_cnt;
  logic [15:0] inq [4];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic run(input int delay);
    int cyc;
    int wait_cnt;
    int in_idx;
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cap_n = 0; ready_cnt = 0; wait_cnt = 0; in_idx = 0; cyc = 0;
    while (!halted && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (out_valid && cap_n < 8) begin
        cap_val[cap_n] = out_data;
        cap_chr[cap_n] = out_is_char;
        cap_n++;
      end
      if (in_ready) ready_cnt++;
      if (in_valid && !in_ready) begin
        in_valid = 1'b0; in_idx++; wait_cnt = 0;
      end else if (in_ready && !in_valid) begin
        if (wait_cnt >= delay) begin
          in_valid = 1'b1;
          in_data = inq[in_idx % 4];
        end else begin
          wait_cnt++;
        end
      end
    end
    if (!halted) chk("R7 run did not halt", 32'd0, 32'd1);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] vals [8];
    logic [15:0] bvals [11];
    logic [15:0] bad [7];
    int delays [3];
    logic [15:0] e;
    vals = '{16'h0000, 16'h0001, 16'h03E7, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h3039, 16'hFED4};
    bvals = '{16'h0000, 16'h0001, 16'h03E7, 16'hFFFF, 16'h7FFF, 16'h8000,
              16'h3039, 16'hFED4, 16'h0002, 16'h4000, 16'hFFFE};
    bad = '{16'h4000, 16'hA000, 16'h9200, 16'h7000, 16'h7200, 16'h0800, 16'h8200};
    delays = '{0, 3, 7};

    // R1: state held in reset before any program
    clear_mem();
    repeat (3) @(negedge clk);
    chk("R1 halted", {31'd0, halted}, 32'd0);
    chk("R1 count", instr_count, 32'd0);
    chk("R1 mem_addr", {24'd0, mem_addr}, 32'd0);

    // R2 R3 R6: arithmetic sweep; 0:LDA 20 1:ADD 21 2:OUT 3:LDA 20 4:SUB 21 5:OUT char 6:STA 22 7:HLT
    foreach (vals[i]) begin
      foreach (vals[j]) begin
        clear_mem();
        mem[0] = 16'hF014; mem[1] = 16'hC015; mem[2] = 16'h7181;
        mem[3] = 16'hF014; mem[4] = 16'hD015; mem[5] = 16'h7182;
        mem[6] = 16'hE016; mem[7] = 16'h0000;
        mem[20] = vals[i]; mem[21] = vals[j];
        run(0);
        e = vals[i] + vals[j];
        chk("R6 output count", cap_n, 32'd2);
        chk("R2 add", {16'd0, cap_val[0]}, {16'd0, e});
        chk("R6 numeric flag", {31'd0, cap_chr[0]}, 32'd0);
        e = vals[i] - vals[j];
        chk("R2 sub", {16'd0, cap_val[1]}, {16'd0, e});
        chk("R6 char flag", {31'd0, cap_chr[1]}, 32'd1);
        chk("R3 store", {16'd0, mem[22]}, {16'd0, e});
        chk("R3 no stray write", {16'd0, mem[23]}, 32'd0);
        chk("R9 count", instr_count, 32'd8);
        repeat (6) @(negedge clk);
        chk("R7 count frozen", instr_count, 32'd8);
        chk("R7 halted held", {31'd0, halted}, 32'd1);
      end
    end

    // R1: reset after a halted run clears state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 halted cleared", {31'd0, halted}, 32'd0);
    chk("R1 count cleared", instr_count, 32'd0);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 in_ready", {31'd0, in_ready}, 32'd0);
    chk("R1 mem_we", {31'd0, mem_we}, 32'd0);
    chk("R1 mem_addr", {24'd0, mem_addr}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first fetch address", {24'd0, mem_addr}, 32'd0);
    chk("R1 illegal", {31'd0, illegal}, 32'd0);

    // R4: 0:LDA 20 1:BRZ 5 2:BRP 7 3:OUT 4:HLT 5:LDA 21 6:BRA 3 7:LDA 22 8:BRA 3
    foreach (bvals[i]) begin
      clear_mem();
      mem[0] = 16'hF014; mem[1] = 16'h9405; mem[2] = 16'h9007; mem[3] = 16'h7181;
      mem[4] = 16'h0000; mem[5] = 16'hF015; mem[6] = 16'h8003; mem[7] = 16'hF016;
      mem[8] = 16'h8003;
      mem[20] = bvals[i]; mem[21] = 16'd111; mem[22] = 16'd222;
      run(0);
      chk("R4 one output", cap_n, 32'd1);
      if (bvals[i] == 16'h0000) begin
        chk("R4 zero path", {16'd0, cap_val[0]}, 32'd111);
        chk("R9 zero path count", instr_count, 32'd6);
      end else if (!bvals[i][15]) begin
        chk("R4 positive path", {16'd0, cap_val[0]}, 32'd222);
        chk("R9 positive path count", instr_count, 32'd7);
      end else begin
        chk("R4 negative path", {16'd0, cap_val[0]}, {16'd0, bvals[i]});
        chk("R9 negative path count", instr_count, 32'd5);
      end
    end

    // R5: 0:INP 1:STA 20 2:INP 3:ADD 20 4:OUT 5:HLT with stalls
    foreach (delays[d]) begin
      clear_mem();
      mem[0] = 16'h7100; mem[1] = 16'hE014; mem[2] = 16'h7100;
      mem[3] = 16'hC014; mem[4] = 16'h7181; mem[5] = 16'h0000;
      inq[0] = 16'd999 + 16'(d); inq[1] = 16'd999; inq[2] = 16'd0; inq[3] = 16'd0;
      run(delays[d]);
      e = inq[0] + inq[1];
      chk("R5 input sum", {16'd0, cap_val[0]}, {16'd0, e});
      chk("R5 first input stored", {16'd0, mem[20]}, {16'd0, inq[0]});
      chk("R5 ready cycles", ready_cnt, 32'(2 * (delays[d] + 1)));
      chk("R9 input count", instr_count, 32'd6);
    end

    // R10: 0:LDA 30 1:ADD 31 2:STA 3 3:(rewritten) 4:OUT 5:HLT
    clear_mem();
    mem[0] = 16'hF01E; mem[1] = 16'hC01F; mem[2] = 16'hE003; mem[3] = 16'h0000;
    mem[4] = 16'h7181; mem[5] = 16'h0000;
    mem[30] = 16'hF000; mem[31] = 16'h0028; mem[40] = 16'h1234;
    run(0);
    chk("R10 rewritten word", {16'd0, mem[3]}, 32'h0000F028);
    chk("R10 rewritten instruction result", {16'd0, cap_val[0]}, 32'h00001234);
    chk("R10 count", instr_count, 32'd6);

    // R7: halt with nonzero low bits; 0:LDA 20 1:07FF 2:STA 21
    clear_mem();
    mem[0] = 16'hF014; mem[1] = 16'h07FF; mem[2] = 16'hE015; mem[20] = 16'h5555;
    run(0);
    repeat (5) @(negedge clk);
    chk("R7 halted", {31'd0, halted}, 32'd1);
    chk("R7 not illegal", {31'd0, illegal}, 32'd0);
    chk("R7 count with halt", instr_count, 32'd2);
    chk("R7 no later store", {16'd0, mem[21]}, 32'd0);

    // R8: 0:LDA 20 1:bad 2:OUT 3:HLT
    foreach (bad[i]) begin
      clear_mem();
      mem[0] = 16'hF014; mem[1] = bad[i]; mem[2] = 16'h7181; mem[3] = 16'h0000;
      mem[20] = 16'h0042;
      run(0);
      chk("R8 illegal", {31'd0, illegal}, 32'd1);
      chk("R8 halted", {31'd0, halted}, 32'd1);
      chk("R8 not counted", instr_count, 32'd1);
      chk("R8 no output", cap_n, 32'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule